// File: doc/BRIEF.md
# Bipolar Line Decoder with Code-Violation Counter

This block takes a line signal on two rails, one for positive marks and one for negative marks, one symbol per accepted transfer. It removes zero-substitution codewords: three-symbol codewords in the DS3/STS-1 line mode and four-symbol codewords in the E3 line mode. It then presents a binary data bit together with a per-bit code-violation flag. Bipolar violations outside valid codewords and excessive-zero runs are detected under a selectable counting policy. Every flagged event increments a saturating internal counter. Software copies that counter into a holding register, and clears it, by raising an update control bit.

A bypass setting disables the decoder: the two rails come out unchanged, with the same latency, and nothing is flagged or counted. An output clock is derived from the block clock. Its polarity selects whether downstream logic samples on its rising or its falling edge. Symbols enter through a valid/ready handshake and leave through another. The pipeline moves only when a symbol is accepted. When the output holds a symbol that has not been taken (`out_valid` high, `out_ready` low), `in_ready` is low and the output is frozen. Line mode, policy and bypass are static settings, changed only while in reset.

Top module: `ldec_line_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `cv_hold` is 0, the internal counter is 0 and no mark has been seen.
- R2: With `line_e3`=0 and `bin_en`=1, a mark whose polarity repeats that of the previous mark (a violation) is part of a codeword when the symbol before it is a zero and the symbol two back is a zero or a non-violation mark. All three symbols of such a codeword are output as 0, every other mark is output as 1, and each symbol's bit appears on `dout_a` after two further symbols have been accepted.
- R3: With `line_e3`=1, a violation is part of a codeword when the two symbols before it are zeros and the symbol three back is a zero or a non-violation mark. All four symbols are output as 0, and each bit appears after three further symbols have been accepted.
- R4: With `cnt_policy`=0, a violation that is not part of a codeword raises `dout_b` on its own bit and adds one to the counter.
- R5: With `cnt_policy`=0, the 3rd consecutive zero (DS3/STS-1) or the 4th consecutive zero (E3) is flagged and counted, once per run.
- R6: With `cnt_policy`=1 in DS3/STS-1 mode, non-codeword violations are still flagged and counted, and excessive-zero runs are neither flagged nor counted.
- R7: With `cnt_policy`=1 in E3 mode, a non-codeword violation is flagged and counted only when its polarity equals that of the previous violation. The previous-violation polarity is positive after reset. Excessive zeros are not flagged.
- R8: With `bin_en`=0, `dout_a` carries the positive rail and `dout_b` the negative rail, with the same latency as decoded data, and the counter does not change.
- R9: A 0-to-1 change of `cv_update` copies the counter into `cv_hold` and clears the counter. An event accepted in that same cycle is counted in the new period. `cv_hold` changes at no other time.
- R10: The counter saturates at all ones (65535 for a 16-bit counter) instead of wrapping.
- R11: With `clk_inv`=0, `out_clk` follows `clk`, so data is stable at its falling edge. With `clk_inv`=1, `out_clk` is inverted, so data is stable at its rising edge.
- R12: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `dout_a`, `dout_b` and `out_valid` hold.
- R13: A symbol with both rails high is a mark of positive polarity. The first mark after reset is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (recovered line clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| line_e3 | input | 1 | 0: DS3/STS-1 three-symbol codewords, 1: E3 four-symbol codewords |
| cnt_policy | input | 1 | Counting policy select (see R4 to R7) |
| bin_en | input | 1 | 1: decoded binary output, 0: rail bypass |
| clk_inv | input | 1 | Output clock polarity select |
| cv_update | input | 1 | Rising edge snapshots and clears the counter |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can accept a symbol |
| in_pos | input | 1 | Positive-mark rail |
| in_neg | input | 1 | Negative-mark rail |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts the output symbol |
| dout_a | output | 1 | Decoded data, or positive rail in bypass |
| dout_b | output | 1 | Code-violation flag, or negative rail in bypass |
| out_clk | output | 1 | Output clock, polarity set by clk_inv |
| cv_hold | output | 16 | Holding register for the violation count |

## Verification
The counter update and a newly flagged violation can happen on the same clock edge. The bench provokes this by driving a repeated positive mark (a non-codeword violation) in the cycle where `cv_update` first goes high. It then judges the result by the snapshot value and by a second snapshot, taken with no traffic, which must read exactly one. Two mode-specific effects are also judged: a codeword clears a mark that is already at the output stage, and the E3 polarity rule depends on the last violation's polarity, including the positive polarity it starts with after reset.

// File: rtl/ldec_pkg.sv
package ldec_pkg;
  // One pipeline slot: raw rails, mark decode, and decoded result
  typedef struct packed {
    logic v;    // slot holds an accepted symbol
    logic p;    // raw positive rail
    logic n;    // raw negative rail
    logic mk;   // symbol is a mark
    logic pl;   // mark polarity, 1 = positive
    logic isv;  // mark repeated previous mark polarity
    logic d;    // decoded data bit
    logic f;    // code-violation flag
  } ldec_sym_t;

  localparam int unsigned LDEC_WIN = 4;
endpackage

// File: rtl/ldec_window.sv
module ldec_window
  import ldec_pkg::*;
#(
  parameter int unsigned WIN = LDEC_WIN
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      take,
  input  logic      pos,
  input  logic      neg,
  input  logic      e3,
  input  logic      pol_sel,
  input  logic      bin_en,
  output ldec_sym_t out_sym,
  output logic      evt
);
  localparam int unsigned ZW      = $clog2(WIN + 1);
  localparam int unsigned CW_LONG = WIN;
  localparam int unsigned CW_SHRT = WIN - 1;

  ldec_sym_t         sr  [WIN];
  ldec_sym_t         nxt [WIN];
  logic              last_pol, seen, last_vpol;
  logic [ZW-1:0]     zrun;
  logic [ZW-1:0]     zlim;
  logic              mk, pl, is_v, cw3, cw4, is_cw, vflag, eflag, exz, flag;
  logic [$clog2(WIN)-1:0] oidx;

  assign mk    = pos | neg;
  assign pl    = pos;
  assign is_v  = mk && seen && (pl == last_pol);
  assign cw3   = !sr[0].mk && (!sr[1].mk || !sr[1].isv);
  assign cw4   = !sr[0].mk && !sr[1].mk && (!sr[2].mk || !sr[2].isv);
  assign is_cw = is_v && (e3 ? cw4 : cw3);
  assign vflag = is_v && !is_cw && (!pol_sel || !e3 || (pl == last_vpol));
  assign zlim  = e3 ? ZW'(CW_LONG) : ZW'(CW_SHRT);
  assign exz   = !mk && ((zrun + ZW'(1)) == zlim);
  assign eflag = exz && !pol_sel;
  assign flag  = bin_en && (vflag || eflag);
  assign evt   = adv && flag;
  assign oidx  = e3 ? $clog2(WIN)'(CW_LONG - 1) : $clog2(WIN)'(CW_SHRT - 1);
  assign out_sym = sr[oidx];

  always_comb begin
    nxt[0] = '{v: 1'b1, p: pos, n: neg, mk: mk, pl: pl, isv: is_v,
               d: mk && !is_cw, f: flag};
    for (int k = 1; k < WIN; k++) begin
      nxt[k] = sr[k-1];
      if (is_cw && (k < (e3 ? CW_LONG : CW_SHRT))) nxt[k].d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < WIN; k++) sr[k] <= '0;
      last_pol  <= 1'b1;
      seen      <= 1'b0;
      last_vpol <= 1'b1;
      zrun      <= '0;
    end else if (adv) begin
      for (int k = 0; k < WIN; k++) sr[k] <= nxt[k];
      if (mk) begin
        last_pol <= pl;
        seen     <= 1'b1;
        zrun     <= '0;
      end else if (zrun != '1) begin
        zrun <= zrun + ZW'(1);
      end
      if (is_v) last_vpol <= pl;
    end else if (take) begin
      sr[oidx].v <= 1'b0;
    end
  end
endmodule

// File: rtl/ldec_cv_counter.sv
module ldec_cv_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             upd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic upd_q, rise;
  assign rise = upd && !upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      cnt   <= '0;
      hold  <= '0;
    end else begin
      upd_q <= upd;
      if (rise) begin
        hold <= cnt;
        cnt  <= CNT_W'(evt);
      end else if (evt && (cnt != CNT_MAX)) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/ldec_line_decoder.sv
module ldec_line_decoder
  import ldec_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_e3,
  input  logic             cnt_policy,
  input  logic             bin_en,
  input  logic             clk_inv,
  input  logic             cv_update,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_pos,
  input  logic             in_neg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             dout_a,
  output logic             dout_b,
  output logic             out_clk,
  output logic [CNT_W-1:0] cv_hold
);
  ldec_sym_t        osym;
  logic             adv, take, cv_evt;
  logic [CNT_W-1:0] cv_cnt;

  assign out_valid = osym.v;
  assign in_ready  = !osym.v || out_ready;
  assign adv       = in_valid && in_ready;
  assign take      = out_ready && osym.v && !adv;

  ldec_window #(.WIN(LDEC_WIN)) win_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .take    (take),
    .pos     (in_pos),
    .neg     (in_neg),
    .e3      (line_e3),
    .pol_sel (cnt_policy),
    .bin_en  (bin_en),
    .out_sym (osym),
    .evt     (cv_evt)
  );

  ldec_cv_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (cv_evt),
    .upd  (cv_update),
    .cnt  (cv_cnt),
    .hold (cv_hold)
  );

  assign dout_a  = bin_en ? osym.d : osym.p;
  assign dout_b  = bin_en ? osym.f : osym.n;
  assign out_clk = clk ^ clk_inv;
endmodule

// File: rtl/ldec_line_decoder_chk.sv
module ldec_line_decoder_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bin_en,
  input logic             cv_update,
  input logic             cv_evt,
  input logic [CNT_W-1:0] cv_cnt,
  input logic [CNT_W-1:0] cv_hold,
  input logic             out_valid,
  input logic             out_ready,
  input logic             dout_a,
  input logic             dout_b
);
  p_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_update) |=> cv_hold == $past(cv_cnt));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_update) |=> cv_cnt == CNT_W'($past(cv_evt)));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cv_update) |=> $stable(cv_hold));

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_cnt == '1) && !$rose(cv_update) |=> cv_cnt == '1);

  p_bypass_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_en |-> !cv_evt);

  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout_a) && $stable(dout_b));
endmodule

bind ldec_line_decoder ldec_line_decoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bin_en    (bin_en),
  .cv_update (cv_update),
  .cv_evt    (cv_evt),
  .cv_cnt    (cv_cnt),
  .cv_hold   (cv_hold),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dout_a    (dout_a),
  .dout_b    (dout_b)
);

// File: tb/ldec_line_decoder_tb_top.sv
module ldec_line_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, line_e3, cnt_policy, bin_en, clk_inv, cv_update;
  logic        in_valid, in_ready, in_pos, in_neg, out_valid, out_ready;
  logic        dout_a, dout_b, out_clk;
  logic [15:0] cv_hold;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ldec_line_decoder dut_i (.*);

  // {start, e3, policy, pos, neg, exp_data, exp_flag}
  localparam int NV = 60;
  localparam logic [6:0] VEC [NV] = '{
    // DS3 policy 0: codewords, bad violation, excess zeros
    7'b1001010, 7'b0000110, 7'b0000000, 7'b0000000, 7'b0000100,
    7'b0001000, 7'b0000000, 7'b0001000, 7'b0000110, 7'b0000111,
    7'b0000000, 7'b0000000, 7'b0000001, 7'b0000000, 7'b0001010,
    7'b0000000, 7'b0000000,
    // E3 policy 0
    7'b1101010, 7'b0100000, 7'b0100000, 7'b0100000, 7'b0101000,
    7'b0100100, 7'b0100000, 7'b0100000, 7'b0100100, 7'b0101010,
    7'b0101011, 7'b0100000, 7'b0100000, 7'b0100000, 7'b0100001,
    7'b0100110, 7'b0100000, 7'b0100000, 7'b0100000,
    // E3 policy 1
    7'b1111010, 7'b0111011, 7'b0110110, 7'b0110110, 7'b0111010,
    7'b0111010, 7'b0111011, 7'b0110000, 7'b0110000, 7'b0110000,
    7'b0110000, 7'b0110110, 7'b0110000, 7'b0110000, 7'b0110000,
    // DS3 policy 1, both rails high
    7'b1011110, 7'b0011011, 7'b0010000, 7'b0010000, 7'b0010000,
    7'b0010000, 7'b0010110, 7'b0010000, 7'b0010000
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic e3, logic pol, logic bin);
    @(negedge clk);
    rst_n = 1'b0; line_e3 = e3; cnt_policy = pol; bin_en = bin;
    cv_update = 1'b0; in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(logic p, logic n);
    in_valid = 1'b1; in_pos = p; in_neg = n;
    @(negedge clk);
    in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0;
  endtask

  task automatic update_pulse();
    cv_update = 1'b1;
    @(negedge clk);
    cv_update = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string req;
    int base, lat, seg_ev, seg;
    clk_inv = 1'b0;
    do_reset(1'b0, 1'b0, 1'b1);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 cv_hold", 32'(cv_hold), 0);

    base = 0; lat = 2; seg_ev = 0; seg = -1; req = "";
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][6]) begin
        if (seg >= 0) begin
          update_pulse();
          check({req, " count"}, 32'(cv_hold), 32'(seg_ev));
        end
        seg++;
        do_reset(VEC[i][5], VEC[i][4], 1'b1);
        base = i; seg_ev = 0; lat = VEC[i][5] ? 3 : 2;
        case (seg)
          0: req = "R2 R4 R5";
          1: req = "R3 R4 R5";
          2: req = "R7";
          default: req = "R6 R13";
        endcase
      end
      send(VEC[i][3], VEC[i][2]);
      seg_ev += int'(VEC[i][0]);
      if (i - base >= lat) begin
        check({req, " valid"}, 32'(out_valid), 1);
        check({req, " data"}, 32'(dout_a), 32'(VEC[i-lat][1]));
        check({req, " flag"}, 32'(dout_b), 32'(VEC[i-lat][0]));
      end
    end
    update_pulse();
    check({req, " count"}, 32'(cv_hold), 32'(seg_ev));

    // R8 bypass: rails pass, nothing counted
    do_reset(1'b0, 1'b0, 1'b0);
    send(1'b1, 1'b0); send(1'b1, 1'b0); send(1'b1, 1'b1);
    check("R8 pos rail", 32'(dout_a), 1);
    check("R8 neg rail", 32'(dout_b), 0);
    send(1'b0, 1'b1);
    check("R8 pos rail 2", 32'(dout_a), 1);
    send(1'b0, 1'b0);
    check("R8 both rails", 32'({dout_a, dout_b}), 3);
    send(1'b0, 1'b0); send(1'b0, 1'b0);
    update_pulse();
    check("R8 count", 32'(cv_hold), 0);

    // R9 update and event in the same cycle
    do_reset(1'b0, 1'b0, 1'b1);
    send(1'b1, 1'b0); send(1'b1, 1'b0);
    cv_update = 1'b1;
    send(1'b1, 1'b0);
    cv_update = 1'b0;
    @(negedge clk);
    check("R9 snapshot", 32'(cv_hold), 1);
    update_pulse();
    check("R9 same-cycle event", 32'(cv_hold), 1);
    @(negedge clk);
    check("R9 hold steady", 32'(cv_hold), 1);

    // R12 back-pressure
    do_reset(1'b0, 1'b0, 1'b1);
    out_ready = 1'b0;
    send(1'b1, 1'b0); send(1'b0, 1'b1); send(1'b1, 1'b0);
    check("R12 out_valid", 32'(out_valid), 1);
    check("R12 in_ready", 32'(in_ready), 0);
    in_valid = 1'b1; in_pos = 1'b0; in_neg = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 data held", 32'(dout_a), 1);
    check("R12 still stalled", 32'({out_valid, in_ready}), 2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 advanced", 32'({out_valid, dout_a}), 3);

    // R10 saturation
    do_reset(1'b0, 1'b0, 1'b1);
    in_valid = 1'b1; in_pos = 1'b1; in_neg = 1'b0;
    repeat (65540) @(negedge clk);
    in_valid = 1'b0; in_pos = 1'b0;
    update_pulse();
    check("R10 saturated", 32'(cv_hold), 65535);

    // R11 output clock polarity
    clk_inv = 1'b0;
    @(negedge clk);
    check("R11 follows low", 32'(out_clk), 0);
    @(posedge clk); #1;
    check("R11 follows high", 32'(out_clk), 1);
    clk_inv = 1'b1;
    @(negedge clk);
    check("R11 inverted", 32'(out_clk), 1);
    @(posedge clk); #1;
    check("R11 inverted high", 32'(out_clk), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule